// File: doc/BRIEF.md
# Serial Slave Front End for a Four-Input, Four-Output Port Expander

This block is the two-wire serial slave of a small port expander with four output bits (O7, O6, O1, O0) and four input bits (I5..I2). It runs from a fast system clock and oversamples the bus clock and data lines. It recognises START and STOP, compares the incoming 7-bit address with an address supplied on an input, acknowledges, and then either accepts data bytes or returns data bytes. On writes, every data byte sets the four output bits and the four interrupt-mask bits. On reads, it returns a port byte and a transition-flag byte in turn, for as long as the master keeps acknowledging.

The slave drives the data line through an open-drain enable. It sends a one-cycle snapshot pulse to the neighbouring transition detector on every acknowledge that comes before a port byte. The detector uses this pulse to sample its inputs and clear its flags. The slave latches the pin levels and the outgoing flags on that same pulse. A STOP pulse and a read-in-progress level are also provided, so the detector can hold its interrupt until the bus is released. An abort input, sampled on the clock, drops any transfer in progress and leaves the output and mask registers untouched.

Top module: `io4_expander_slave`

## Requirements
- R1: START (data falling while clock high) begins a transfer from any state, including a repeated START inside a transfer. STOP (data rising while clock high) returns the slave to idle, clears `read_busy` and produces one `stop_pulse`.
- R2: The first byte after START is the 7-bit address, MSB first, followed by the R/W bit (1 = read). If the address differs from `dev_addr`, the slave never drives the data line until the next START, and the outputs and mask do not change.
- R3: On the 9th clock of the address byte (when it matches) and of every write data byte, the slave pulls the data line low.
- R4: A write data byte maps bits 7, 6, 1, 0 to `out_val[3:0]` (O7, O6, O1, O0) and bits 5..2 to `int_mask[3:0]` (mask for I5..I2).
- R5: Each further data byte in the same write updates the outputs and the mask again.
- R6: New output and mask values appear while the 9th (acknowledge) clock of the byte that carries them is high, and not before.
- R7: A port byte is {O7, O6, I5, I4, I3, I2, O1, O0}. The O bits come from `out_sense` and the I bits from `in_pins`. Both are sampled during the acknowledge bit that precedes the byte; for the first byte, this is the address acknowledge.
- R8: A flag byte is {0, 0, flags_i[3:0], 0, 0}. It carries the flag values latched on the same snapshot pulse as the port byte that precedes it.
- R9: A read returns port, flag, port, flag, ... until the master sends NACK. The slave does not drive the data line on the 9th clock of bytes it transmits.
- R10: `snap_pulse` is one clock wide. It fires once per address acknowledge and once per master acknowledge that comes before a port byte, and at no other time.
- R11: Holding `bus_rst_n` low drops the transfer in progress, so the rest of that byte is not acknowledged. It does not change `out_val` or `int_mask`.
- R12: After `rst_n`, the outputs equal `OUT_RESET` (default 4'b1111), the mask equals `MASK_RESET` (default 4'b1111), and the data line is released.
- R13: The slave changes its data-line enable only while the bus clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times the bus clock rate |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| bus_rst_n | input | 1 | Active-low transfer abort, sampled on clk |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 = pull the data line low |
| dev_addr | input | 7 | Address this slave answers to |
| in_pins | input | 4 | Input pin levels I5..I2 |
| out_sense | input | 4 | Output pin levels as seen on the pins, O7, O6, O1, O0 |
| flags_i | input | 4 | Transition flags from the detector, I5..I2 |
| out_val | output | 4 | Output register O7, O6, O1, O0 |
| int_mask | output | 4 | Interrupt mask for I5..I2 |
| snap_pulse | output | 1 | Sample inputs and clear flags |
| stop_pulse | output | 1 | One pulse per STOP seen |
| read_busy | output | 1 | High from a read address match until STOP or START |

## Verification
The assertions assume a well-behaved master. It changes the data line only while the bus clock is low, except when it makes START or STOP, and it never makes START or STOP while the slave holds the line low. Each bus clock phase must also last longer than the synchroniser latency plus a few cycles. The bench drives the bus with a quarter-bit period of eight system clocks and follows the open-drain rule, so the line is the AND of the master's level and the slave's release. Aborts are applied only while the slave is receiving.

// File: rtl/pxe_pkg.sv
package pxe_pkg;
   localparam int BYTE_W = 8;
   localparam int NPORT  = 4;
   localparam int ADDR_W = 7;
   localparam int CNT_W  = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] BYTE_CNT = CNT_W'(BYTE_W);

   typedef enum logic [2:0] {
      ST_IDLE, ST_ADDR, ST_AACK, ST_WDATA, ST_WACK, ST_RDATA, ST_RACK, ST_SKIP
   } phase_t;

   // outputs sit at byte bits 7,6,1,0; inputs or mask at bits 5..2
   function automatic logic [BYTE_W-1:0] pack_port(input logic [NPORT-1:0] o,
                                                   input logic [NPORT-1:0] i);
      return {o[3], o[2], i, o[1], o[0]};
   endfunction

   function automatic logic [BYTE_W-1:0] pack_flags(input logic [NPORT-1:0] f);
      return {2'b00, f, 2'b00};
   endfunction

   function automatic logic [NPORT-1:0] pick_outs(input logic [BYTE_W-1:0] b);
      return {b[7], b[6], b[1], b[0]};
   endfunction

   function automatic logic [NPORT-1:0] pick_mask(input logic [BYTE_W-1:0] b);
      return b[5:2];
   endfunction
endpackage

// File: rtl/pxe_line_sync.sv
module pxe_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pxe_line_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] scl_q, sda_q;
   logic              scl_d, sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= '1;
         sda_q <= '1;
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_q <= {scl_q[STAGES-2:0], scl_i};
         sda_q <= {sda_q[STAGES-2:0], sda_i};
         scl_d <= scl_q[STAGES-1];
         sda_d <= sda_q[STAGES-1];
      end
   end

   assign scl_s     = scl_q[STAGES-1];
   assign sda_s     = sda_q[STAGES-1];
   assign scl_rise  = scl_s & ~scl_d;
   assign scl_fall  = ~scl_s & scl_d;
   assign start_det = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/pxe_bit_fsm.sv
module pxe_bit_fsm
   import pxe_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_rst_n,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic              sda_s,
   input  logic [ADDR_W-1:0] dev_addr,
   input  logic [BYTE_W-1:0] port_byte,
   input  logic [BYTE_W-1:0] flag_byte,
   output logic              drive_low,
   output logic              wr_strobe,
   output logic [BYTE_W-1:0] wr_byte,
   output logic              snap_pulse,
   output logic              read_busy
);
   phase_t            state;
   logic [CNT_W-1:0]  bitcnt;
   logic [BYTE_W-1:0] rx, tx;
   logic              rw, flag_next, snap_q, wr_q, rd_act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         bitcnt    <= '0;
         rx        <= '0;
         tx        <= '0;
         rw        <= 1'b0;
         flag_next <= 1'b0;
         snap_q    <= 1'b0;
         wr_q      <= 1'b0;
         rd_act    <= 1'b0;
      end else begin
         snap_q <= 1'b0;
         wr_q   <= 1'b0;
         if (!bus_rst_n) begin
            state  <= ST_IDLE;
            bitcnt <= '0;
            rd_act <= 1'b0;
         end else if (start_det) begin
            state  <= ST_ADDR;
            bitcnt <= '0;
            rd_act <= 1'b0;
         end else if (stop_det) begin
            state  <= ST_IDLE;
            rd_act <= 1'b0;
         end else begin
            case (state)
               ST_ADDR, ST_WDATA: begin
                  if (scl_rise) begin
                     rx     <= {rx[BYTE_W-2:0], sda_s};
                     bitcnt <= bitcnt + 1'b1;
                  end else if (scl_fall && bitcnt == BYTE_CNT) begin
                     bitcnt <= '0;
                     if (state == ST_WDATA) begin
                        state <= ST_WACK;
                     end else if (rx[BYTE_W-1:1] == dev_addr) begin
                        state  <= ST_AACK;
                        rw     <= rx[0];
                        rd_act <= rx[0];
                     end else begin
                        state <= ST_SKIP;
                     end
                  end
               end
               ST_AACK: begin
                  if (scl_rise) begin
                     snap_q <= 1'b1;
                  end else if (scl_fall) begin
                     if (rw) begin
                        state     <= ST_RDATA;
                        tx        <= port_byte;
                        flag_next <= 1'b1;
                     end else begin
                        state <= ST_WDATA;
                     end
                  end
               end
               ST_WACK: begin
                  if (scl_rise) wr_q <= 1'b1;
                  else if (scl_fall) state <= ST_WDATA;
               end
               ST_RDATA: begin
                  if (scl_rise) begin
                     bitcnt <= bitcnt + 1'b1;
                  end else if (scl_fall) begin
                     if (bitcnt == BYTE_CNT) begin
                        state  <= ST_RACK;
                        bitcnt <= '0;
                     end else begin
                        tx <= {tx[BYTE_W-2:0], 1'b0};
                     end
                  end
               end
               ST_RACK: begin
                  if (scl_rise) begin
                     if (sda_s) state <= ST_SKIP;
                     else if (!flag_next) snap_q <= 1'b1;
                  end else if (scl_fall) begin
                     state     <= ST_RDATA;
                     tx        <= flag_next ? flag_byte : port_byte;
                     flag_next <= ~flag_next;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      case (state)
         ST_AACK, ST_WACK: drive_low = 1'b1;
         ST_RDATA:         drive_low = ~tx[BYTE_W-1];
         default:          drive_low = 1'b0;
      endcase
   end

   assign wr_strobe  = wr_q;
   assign wr_byte    = rx;
   assign snap_pulse = snap_q;
   assign read_busy  = rd_act;

   // R10
   snap_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snap_q |=> !snap_q);

   // R3
   bit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bitcnt <= BYTE_CNT);

   // R2
   skip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SKIP && !start_det && !stop_det && bus_rst_n) |=> state == ST_SKIP);
endmodule

// File: rtl/io4_expander_slave.sv
module io4_expander_slave
   import pxe_pkg::*;
#(
   parameter int               SYNC_STAGES = 2,
   parameter bit               REG_SDA_OUT = 1'b1,
   parameter logic [NPORT-1:0] OUT_RESET   = 4'b1111,
   parameter logic [NPORT-1:0] MASK_RESET  = 4'b1111
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   input  logic [ADDR_W-1:0] dev_addr,
   input  logic [NPORT-1:0]  in_pins,
   input  logic [NPORT-1:0]  out_sense,
   input  logic [NPORT-1:0]  flags_i,
   output logic [NPORT-1:0]  out_val,
   output logic [NPORT-1:0]  int_mask,
   output logic              snap_pulse,
   output logic              stop_pulse,
   output logic              read_busy
);
   generate
      if (NPORT != 4 || BYTE_W != 8) begin : g_bad_geom
         $error("io4_expander_slave: byte layout needs four ports in eight bits");
      end
   endgenerate

   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic drive_low, wr_strobe, snap_int;
   logic [BYTE_W-1:0] wr_byte, port_byte, flag_byte;
   logic stop_q;

   pxe_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   pxe_bit_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .bus_rst_n(bus_rst_n),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s),
      .dev_addr(dev_addr), .port_byte(port_byte), .flag_byte(flag_byte),
      .drive_low(drive_low), .wr_strobe(wr_strobe), .wr_byte(wr_byte),
      .snap_pulse(snap_int), .read_busy(read_busy)
   );

   // pin and flag capture on each snapshot; outputs and mask on each write ACK
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         port_byte <= '0;
         flag_byte <= '0;
         out_val   <= OUT_RESET;
         int_mask  <= MASK_RESET;
         stop_q    <= 1'b0;
      end else begin
         stop_q <= stop_det;
         if (snap_int) begin
            port_byte <= pack_port(out_sense, in_pins);
            flag_byte <= pack_flags(flags_i);
         end
         if (wr_strobe) begin
            out_val  <= pick_outs(wr_byte);
            int_mask <= pick_mask(wr_byte);
         end
      end
   end

   generate
      if (REG_SDA_OUT) begin : g_reg_oe
         logic oe_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) oe_q <= 1'b0;
            else        oe_q <= bus_rst_n & drive_low;
         end
         assign sda_oe = oe_q;
      end else begin : g_comb_oe
         assign sda_oe = drive_low;
      end
   endgenerate

   assign snap_pulse = snap_int;
   assign stop_pulse = stop_q;

   // R13
   sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !bus_rst_n)
      (scl_s && $past(scl_s)) |-> $stable(sda_oe));

   // R6
   commit_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_strobe |-> scl_s);

   // R6
   out_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(out_val) |-> $past(wr_strobe));
endmodule

// File: tb/tb_io4_expander_slave.sv
module tb_io4_expander_slave;
   localparam int Q = 8;
   localparam logic [6:0] MY_ADDR = 7'h61;

   logic clk = 1'b0;
   logic rst_n = 1'b0, bus_rst_n = 1'b1;
   logic scl = 1'b1, sda_m = 1'b1;
   logic sda_oe;
   logic [3:0] in_pins = 4'b0000, flags_i = 4'b0000, sense_ovr = 4'b0000;
   logic use_ovr = 1'b0;
   logic [3:0] out_val, int_mask, out_sense;
   logic snap_pulse, stop_pulse, read_busy;
   int n_chk = 0, n_err = 0, snap_cnt = 0, stop_cnt = 0, oe_cnt = 0;

   wire sda_line = sda_m & ~sda_oe;
   assign out_sense = use_ovr ? sense_ovr : out_val;

   always #10 clk = ~clk;

   io4_expander_slave dut (
      .clk(clk), .rst_n(rst_n), .bus_rst_n(bus_rst_n), .scl_i(scl), .sda_i(sda_line),
      .sda_oe(sda_oe), .dev_addr(MY_ADDR), .in_pins(in_pins), .out_sense(out_sense),
      .flags_i(flags_i), .out_val(out_val), .int_mask(int_mask),
      .snap_pulse(snap_pulse), .stop_pulse(stop_pulse), .read_busy(read_busy)
   );

   always @(posedge clk) begin
      if (snap_pulse) snap_cnt++;
      if (stop_pulse) stop_cnt++;
      if (sda_oe) oe_cnt++;
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic bit_xfer(input logic b, output logic r);
      tick(Q); sda_m = b; tick(Q); scl = 1'b1; tick(Q); r = sda_line; tick(Q); scl = 1'b0;
   endtask

   task automatic bus_start();
      sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl = 1'b0;
   endtask

   task automatic bus_stop();
      tick(Q); sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b1; tick(4 * Q);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic acked);
      logic r;
      for (int i = 7; i >= 0; i--) bit_xfer(b[i], r);
      bit_xfer(1'b1, r);
      acked = ~r;
   endtask

   task automatic recv_byte(input logic mack, output logic [7:0] d, output logic ack_line);
      logic r;
      for (int i = 7; i >= 0; i--) begin
         bit_xfer(1'b1, r);
         d[i] = r;
      end
      bit_xfer(~mack, ack_line);
   endtask

   task automatic t_reset();
      chk("R12 out_val", out_val, 4'b1111);
      chk("R12 int_mask", int_mask, 4'b1111);
      chk("R12 sda_oe", sda_oe, 1'b0);
      chk("R1 read_busy idle", read_busy, 1'b0);
   endtask

   task automatic t_write();
      logic a, r;
      int s0;
      s0 = snap_cnt;
      bus_start();
      send_byte({MY_ADDR, 1'b0}, a);
      chk("R3 address ack", a, 1'b1);
      chk("R10 snap on address ack", snap_cnt - s0, 1);
      for (int i = 7; i >= 0; i--) bit_xfer(8'h96 >> i, r);
      chk("R6 outputs before ack clock", out_val, 4'b1111);
      tick(Q); sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
      chk("R3 data ack", sda_line, 1'b0);
      chk("R4 R6 outputs on ack clock", out_val, 4'b1010);
      chk("R4 mask", int_mask, 4'b0101);
      tick(Q); scl = 1'b0;
      send_byte(8'h69, a);
      chk("R5 second byte outputs", out_val, 4'b0101);
      chk("R5 second byte mask", int_mask, 4'b1010);
      chk("R10 no snap on data bytes", snap_cnt - s0, 1);
      s0 = stop_cnt;
      bus_stop();
      chk("R1 stop pulse", stop_cnt - s0, 1);
   endtask

   task automatic t_wrong_addr();
      logic a;
      int o0;
      o0 = oe_cnt;
      bus_start();
      send_byte({7'h62, 1'b0}, a);
      chk("R2 foreign address not acked", a, 1'b0);
      send_byte(8'h00, a);
      bus_stop();
      chk("R2 sda never driven", oe_cnt - o0, 0);
      chk("R2 outputs kept", out_val, 4'b0101);
   endtask

   task automatic t_read();
      logic a, al;
      logic [7:0] d;
      int s0;
      use_ovr = 1'b1; sense_ovr = 4'b0110; in_pins = 4'b1011; flags_i = 4'b0101;
      s0 = snap_cnt;
      bus_start();
      send_byte({MY_ADDR, 1'b1}, a);
      chk("R3 read address ack", a, 1'b1);
      in_pins = 4'b0000; flags_i = 4'b1111;
      chk("R1 read_busy during read", read_busy, 1'b1);
      recv_byte(1'b1, d, al);
      chk("R7 port byte from address ack", d, 8'h6E);
      recv_byte(1'b1, d, al);
      chk("R8 flag byte", d, 8'h14);
      flags_i = 4'b1000;
      recv_byte(1'b1, d, al);
      chk("R9 R7 third byte resampled", d, 8'h42);
      recv_byte(1'b0, d, al);
      chk("R9 R8 fourth byte flags", d, 8'h3C);
      chk("R9 slave released on nack clock", al, 1'b1);
      chk("R10 two snapshots in read", snap_cnt - s0, 2);
      bus_stop();
      chk("R1 read_busy after stop", read_busy, 1'b0);
      use_ovr = 1'b0;
   endtask

   task automatic t_abort();
      logic a, r;
      bus_start();
      send_byte({MY_ADDR, 1'b0}, a);
      for (int i = 0; i < 4; i++) bit_xfer(1'b0, r);
      bus_rst_n = 1'b0; tick(3); bus_rst_n = 1'b1;
      send_byte(8'h0F, a);
      chk("R11 aborted byte not acked", a, 1'b0);
      chk("R11 outputs kept", out_val, 4'b0101);
      chk("R11 mask kept", int_mask, 4'b1010);
      bus_stop();
      bus_start();
      send_byte({MY_ADDR, 1'b0}, a);
      send_byte(8'h3C, a);
      bus_stop();
      chk("R11 write after abort", {out_val, int_mask}, 8'h0F);
   endtask

   task automatic t_restart();
      logic a, al;
      logic [7:0] d;
      in_pins = 4'b0101;
      bus_start();
      send_byte({MY_ADDR, 1'b0}, a);
      send_byte(8'hC3, a);
      chk("R4 write before restart", {out_val, int_mask}, 8'hF0);
      bus_start();
      send_byte({MY_ADDR, 1'b1}, a);
      chk("R1 repeated start address ack", a, 1'b1);
      recv_byte(1'b0, d, al);
      chk("R1 R7 read after repeated start", d, 8'hD7);
      bus_stop();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL R1 watchdog act=timeout exp=done");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      tick(5);
      rst_n = 1'b1;
      tick(5);
      t_reset();
      t_write();
      t_wrong_addr();
      t_read();
      t_abort();
      t_restart();
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule